// File: doc/BRIEF.md
# Shared-Line Store Ownership Upgrade Sequencer

This controller completes write-back stores against a data cache. A store can hit a line that the cache already owns (exclusive or modified). In that case the store bytes are merged into the line and the line is written back at once as modified.

A store can also hit a line that is only held in a shared or recently-read state. The cache may not change such a line until it gains sole ownership. The sequencer first removes the line from the array by invalidating it. It then combines the line's old contents with the new store bytes in a reload buffer. Next it broadcasts an address-only kill on the system bus, and it keeps reissuing that kill until the bus acknowledges it. Once the kill is acknowledged, it writes the combined line back into the array in modified state.

The block handles one store at a time. A new store is held off by a busy indication until the current store, including any reload write, has finished. The cache array and the bus are external models. The array read returns data and state one cycle after the read strobe. Writes and invalidations take effect at the clock edge that samples them.

Top module: `upg_seq_top`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `st_busy`, `st_done`, `st_miss`, `kill_req` and every cache strobe are low.
- R2: Line states are encoded as invalid=0, shared=1, recent=2, exclusive=3 and modified=4. A store to a line in exclusive or modified state writes the merged line with state 4 in the cycle after acceptance, raises `st_done` in that same cycle with `st_miss` low, and issues no kill.
- R3: A store to an invalid line raises `st_done` and `st_miss` together in the cycle after acceptance. It leaves the array's data and state unchanged and issues no kill.
- R4: A store to a shared (1) or recent (2) line invalidates that line in the cycle after acceptance. The line reads as invalid in the array for as long as the kill is in progress.
- R5: Merging works on byte lanes. Line byte b occupies bits [8b+7:8b]. The store selects the 8-byte word given by `st_addr[4:3]`, and `st_be[k]` replaces byte k of that word with `st_wdata[8k+7:8k]`. Every other byte keeps its current value.
- R6: The kill carries the line index `st_addr[11:5]` on `kill_addr`. `kill_req` stays high until `kill_ack` or `kill_retry` is seen.
- R7: After a retry, `kill_req` is low for exactly one cycle and is then raised again. This repeats until an acknowledge arrives, so the number of kill issues equals the number of retries plus one.
- R8: In the cycle after the acknowledge, the merged line is written with state 4 and `st_done` is raised. `st_done` is never raised for an upgrade before its acknowledge.
- R9: A request is accepted only on a cycle where `st_valid` is high and `st_busy` is low. `st_busy` stays high from the cycle after acceptance through the cycle of the final write. A following store to the same line therefore sees the upgraded line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request valid; held until accepted |
| st_addr | input | ADDR_W | Store byte address |
| st_be | input | 8 | Byte enables within the selected word |
| st_wdata | input | 64 | Store word data |
| st_busy | output | 1 | A store is in progress; requests stall |
| st_done | output | 1 | One-cycle pulse: store finished |
| st_miss | output | 1 | With st_done: line was invalid, nothing written |
| c_rd_en | output | 1 | Array read strobe |
| c_inv_en | output | 1 | Array invalidate strobe |
| c_wr_en | output | 1 | Array write strobe |
| c_idx | output | ADDR_W-5 | Array line index for all strobes |
| c_rd_data | input | 256 | Line data, one cycle after read |
| c_rd_state | input | 3 | Line state, one cycle after read |
| c_wr_data | output | 256 | Line data to write |
| c_wr_state | output | 3 | Line state to write |
| kill_req | output | 1 | Address-only kill request |
| kill_addr | output | ADDR_W-5 | Line index of the kill |
| kill_ack | input | 1 | Kill succeeded |
| kill_retry | input | 1 | Kill must be reissued |

## Verification
The assertions assume a well-behaved bus. `kill_ack` and `kill_retry` only arrive while `kill_req` is high, and never in the same cycle. They also assume the array answers each read in the following cycle.

The bench's bus model respects both rules. It raises a response only after it has seen `kill_req` high, and it draws a random delay and a preset number of retries before acknowledging. Its array model registers the read result at the clock edge.

Random stores go to a small set of lines so that the same line is hit repeatedly. Directed cases force each line state, zero and full byte enables, long retry chains and back-to-back stores to one line.

// File: rtl/upg_pkg.sv
package upg_pkg;
    localparam int LINE_BYTES = 32;
    localparam int WORD_BYTES = 8;
    localparam int LINE_W     = LINE_BYTES * 8;
    localparam int WORD_W     = WORD_BYTES * 8;
    localparam int OFS_W      = $clog2(LINE_BYTES);
    localparam int WSEL_W     = $clog2(LINE_BYTES / WORD_BYTES);
    localparam int BSEL_W     = $clog2(WORD_BYTES);

    typedef enum logic [2:0] {
        LS_INV = 3'd0,
        LS_SHR = 3'd1,
        LS_RCT = 3'd2,
        LS_EXC = 3'd3,
        LS_MOD = 3'd4
    } line_st_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_LOOK,
        SQ_KILL,
        SQ_RELOAD
    } seq_e;

    typedef enum logic [1:0] {
        KB_IDLE,
        KB_REQ,
        KB_GAP
    } kb_e;

    typedef struct packed {
        logic [WSEL_W-1:0]     wsel;
        logic [WORD_BYTES-1:0] be;
        logic [WORD_W-1:0]     data;
    } st_frag_t;

    function automatic logic [LINE_W-1:0] merge_line(input logic [LINE_W-1:0] cur,
                                                     input st_frag_t frag);
        logic [LINE_W-1:0] res;
        res = cur;
        for (int b = 0; b < LINE_BYTES; b++) begin
            if ((b / WORD_BYTES) == int'(frag.wsel) && frag.be[b % WORD_BYTES])
                res[8*b +: 8] = frag.data[8*(b % WORD_BYTES) +: 8];
        end
        return res;
    endfunction

    function automatic logic needs_upgrade(input line_st_e s);
        return (s == LS_SHR) || (s == LS_RCT);
    endfunction

    function automatic logic is_owned(input line_st_e s);
        return (s == LS_EXC) || (s == LS_MOD);
    endfunction
endpackage

// File: rtl/upg_rbuf.sv
module upg_rbuf
    import upg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [LINE_W-1:0] cur_line,
    input  st_frag_t          frag,
    output logic [LINE_W-1:0] merged,
    output logic [LINE_W-1:0] held
);
    assign merged = merge_line(cur_line, frag);

    always_ff @(posedge clk) begin
        if (rst)
            held <= '0;
        else if (load)
            held <= merged;
    end
endmodule

// File: rtl/upg_killer.sv
module upg_killer
    import upg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic kill_ack,
    input  logic kill_retry,
    output logic kill_req,
    output logic granted
);
    kb_e kb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            kb_q <= KB_IDLE;
        end else begin
            unique case (kb_q)
                KB_IDLE: if (start) kb_q <= KB_REQ;
                KB_REQ: begin
                    if (kill_ack)        kb_q <= KB_IDLE;
                    else if (kill_retry) kb_q <= KB_GAP;
                end
                KB_GAP:  kb_q <= KB_REQ;
                default: kb_q <= KB_IDLE;
            endcase
        end
    end

    assign kill_req = (kb_q == KB_REQ);
    assign granted  = kill_req && kill_ack;

    AST_BUS_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (kill_ack || kill_retry) |-> (kill_req && !(kill_ack && kill_retry))); // R6
    AST_KILL_HELD: assert property (@(posedge clk) disable iff (rst)
        (kill_req && !kill_ack && !kill_retry) |=> kill_req); // R6
    AST_RETRY_GAP: assert property (@(posedge clk) disable iff (rst)
        (kill_req && kill_retry && !kill_ack) |=> !kill_req); // R7
    AST_REISSUE: assert property (@(posedge clk) disable iff (rst)
        (kill_req && kill_retry && !kill_ack) |=> ##1 kill_req); // R7
endmodule

// File: rtl/upg_ctrl.sv
module upg_ctrl
    import upg_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             st_valid,
    input  logic [IDX_W-1:0] st_idx,
    input  st_frag_t         st_frag,
    input  line_st_e         cur_state,
    input  logic             granted,
    output logic             busy,
    output logic             done,
    output logic             miss,
    output logic             rd_en,
    output logic             inv_en,
    output logic             wr_en,
    output logic             wr_from_buf,
    output logic             buf_load,
    output logic             kill_start,
    output logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] idx_q,
    output st_frag_t         frag_q
);
    seq_e sq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sq_q   <= SQ_IDLE;
            idx_q  <= '0;
            frag_q <= '0;
        end else begin
            unique case (sq_q)
                SQ_IDLE: if (st_valid) begin
                    sq_q   <= SQ_LOOK;
                    idx_q  <= st_idx;
                    frag_q <= st_frag;
                end
                SQ_LOOK:   sq_q <= needs_upgrade(cur_state) ? SQ_KILL : SQ_IDLE;
                SQ_KILL:   if (granted) sq_q <= SQ_RELOAD;
                SQ_RELOAD: sq_q <= SQ_IDLE;
                default:   sq_q <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        rd_en       = 1'b0;
        inv_en      = 1'b0;
        wr_en       = 1'b0;
        wr_from_buf = 1'b0;
        buf_load    = 1'b0;
        kill_start  = 1'b0;
        done        = 1'b0;
        miss        = 1'b0;
        idx         = idx_q;
        unique case (sq_q)
            SQ_IDLE: begin
                rd_en = st_valid;
                idx   = st_idx;
            end
            SQ_LOOK: begin
                if (is_owned(cur_state)) begin
                    wr_en = 1'b1;
                    done  = 1'b1;
                end else if (needs_upgrade(cur_state)) begin
                    inv_en     = 1'b1;
                    buf_load   = 1'b1;
                    kill_start = 1'b1;
                end else begin
                    done = 1'b1;
                    miss = 1'b1;
                end
            end
            SQ_RELOAD: begin
                wr_en       = 1'b1;
                wr_from_buf = 1'b1;
                done        = 1'b1;
            end
            default: ;
        endcase
    end

    assign busy = (sq_q != SQ_IDLE);

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_en, inv_en, wr_en})); // R2
    AST_STALL: assert property (@(posedge clk) disable iff (rst)
        busy |-> !rd_en); // R9
    AST_RELOAD_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        (sq_q == SQ_RELOAD) |-> $past(granted)); // R8
    AST_MISS_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        miss |-> (!wr_en && !inv_en && !kill_start)); // R3
endmodule

// File: rtl/upg_seq_top.sv
module upg_seq_top
    import upg_pkg::*;
#(
    parameter int ADDR_W = 12,
    localparam int IDX_W = ADDR_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [7:0]        st_be,
    input  logic [63:0]       st_wdata,
    output logic              st_busy,
    output logic              st_done,
    output logic              st_miss,
    output logic              c_rd_en,
    output logic              c_inv_en,
    output logic              c_wr_en,
    output logic [IDX_W-1:0]  c_idx,
    input  logic [255:0]      c_rd_data,
    input  logic [2:0]        c_rd_state,
    output logic [255:0]      c_wr_data,
    output logic [2:0]        c_wr_state,
    output logic              kill_req,
    output logic [IDX_W-1:0]  kill_addr,
    input  logic              kill_ack,
    input  logic              kill_retry
);
    st_frag_t          in_frag, frag_q;
    logic [IDX_W-1:0]  idx_q;
    logic              granted, kill_start, buf_load, wr_from_buf;
    logic [LINE_W-1:0] merged, held;

    assign in_frag.wsel = st_addr[OFS_W-1:BSEL_W];
    assign in_frag.be   = st_be;
    assign in_frag.data = st_wdata;

    upg_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .st_valid   (st_valid),
        .st_idx     (st_addr[ADDR_W-1:OFS_W]),
        .st_frag    (in_frag),
        .cur_state  (line_st_e'(c_rd_state)),
        .granted    (granted),
        .busy       (st_busy),
        .done       (st_done),
        .miss       (st_miss),
        .rd_en      (c_rd_en),
        .inv_en     (c_inv_en),
        .wr_en      (c_wr_en),
        .wr_from_buf(wr_from_buf),
        .buf_load   (buf_load),
        .kill_start (kill_start),
        .idx        (c_idx),
        .idx_q      (idx_q),
        .frag_q     (frag_q)
    );

    upg_rbuf u_rbuf (
        .clk     (clk),
        .rst     (rst),
        .load    (buf_load),
        .cur_line(c_rd_data),
        .frag    (frag_q),
        .merged  (merged),
        .held    (held)
    );

    upg_killer u_kill (
        .clk       (clk),
        .rst       (rst),
        .start     (kill_start),
        .kill_ack  (kill_ack),
        .kill_retry(kill_retry),
        .kill_req  (kill_req),
        .granted   (granted)
    );

    assign kill_addr  = idx_q;
    assign c_wr_data  = wr_from_buf ? held : merged;
    assign c_wr_state = LS_MOD;

    AST_INV_THEN_KILL: assert property (@(posedge clk) disable iff (rst)
        c_inv_en |=> kill_req); // R4
    AST_KILL_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        !st_busy |-> !kill_req); // R9
    AST_DONE_NOT_IN_KILL: assert property (@(posedge clk) disable iff (rst)
        kill_req |-> !st_done); // R8
endmodule

// File: tb/tb_upg_seq_top.sv
`timescale 1ns/1ps
module tb_upg_seq_top;
    localparam int NL = 128;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic st_valid = 1'b0;
    logic [11:0] st_addr = '0;
    logic [7:0]  st_be = '0;
    logic [63:0] st_wdata = '0;
    logic st_busy, st_done, st_miss, c_rd_en, c_inv_en, c_wr_en, kill_req;
    logic [6:0] c_idx, kill_addr;
    logic [255:0] c_rd_data, c_wr_data;
    logic [2:0] c_rd_state, c_wr_state;
    logic kill_ack = 1'b0;
    logic kill_retry = 1'b0;

    always #2.5 clk = ~clk;

    upg_seq_top dut (
        .clk(clk), .rst(rst), .st_valid(st_valid), .st_addr(st_addr), .st_be(st_be),
        .st_wdata(st_wdata), .st_busy(st_busy), .st_done(st_done), .st_miss(st_miss),
        .c_rd_en(c_rd_en), .c_inv_en(c_inv_en), .c_wr_en(c_wr_en), .c_idx(c_idx),
        .c_rd_data(c_rd_data), .c_rd_state(c_rd_state), .c_wr_data(c_wr_data),
        .c_wr_state(c_wr_state), .kill_req(kill_req), .kill_addr(kill_addr),
        .kill_ack(kill_ack), .kill_retry(kill_retry)
    );

    // array model and independent expectation
    logic [255:0] mdl_d [NL];
    logic [2:0]   mdl_s [NL];
    logic [255:0] exp_d [NL];
    logic [2:0]   exp_s [NL];

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always @(posedge clk) begin
        if (c_rd_en) begin
            c_rd_data  <= mdl_d[c_idx];
            c_rd_state <= mdl_s[c_idx];
        end
        if (c_inv_en) mdl_s[c_idx] <= 3'd0;
        if (c_wr_en) begin
            mdl_d[c_idx] <= c_wr_data;
            mdl_s[c_idx] <= c_wr_state;
        end
    end

    // bus model
    int retries_left = 0;
    int wait_cnt = 0;
    int kills_seen = 0;
    bit ack_seen = 0;
    bit inv_bad = 0;
    bit kreq_prev = 0;
    logic [6:0] cur_idx = '0;

    always @(negedge clk) begin
        if (kill_req && !kreq_prev) begin
            kills_seen++;
            if (mdl_s[kill_addr] != 3'd0 || kill_addr != cur_idx) inv_bad = 1;
        end
        kreq_prev = kill_req;
        if (kill_req && !kill_ack && !kill_retry) begin
            if (mdl_s[kill_addr] != 3'd0) inv_bad = 1;
            if (wait_cnt > 0) wait_cnt--;
            else if (retries_left > 0) begin
                kill_retry = 1'b1;
                retries_left--;
                wait_cnt = $urandom % 3;
            end else begin
                kill_ack = 1'b1;
                ack_seen = 1;
            end
        end else begin
            kill_ack = 1'b0;
            kill_retry = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [255:0] ref_merge(input logic [255:0] cur, input logic [11:0] a,
                                               input logic [7:0] be, input logic [63:0] d);
        logic [255:0] r;
        r = cur;
        for (int b = 0; b < 32; b++)
            if ((b / 8) == int'(a[4:3]) && be[b % 8]) r[8*b +: 8] = d[8*(b % 8) +: 8];
        return r;
    endfunction

    task automatic do_store(input logic [11:0] a, input logic [7:0] be,
                            input logic [63:0] d, input int retries);
        logic [6:0]   idx;
        logic [2:0]   pre;
        logic [255:0] want;
        bit upg;
        bit busy_err;
        int guard;
        idx  = a[11:5];
        pre  = exp_s[idx];
        upg  = (pre == 3'd1) || (pre == 3'd2);
        want = (pre == 3'd0) ? exp_d[idx] : ref_merge(exp_d[idx], a, be, d);
        @(negedge clk);
        retries_left = retries; wait_cnt = $urandom % 3;
        kills_seen = 0; ack_seen = 0; inv_bad = 0; cur_idx = idx;
        st_valid = 1'b1; st_addr = a; st_be = be; st_wdata = d;
        while (st_busy) @(negedge clk);
        @(negedge clk);
        st_valid = 1'b0;
        guard = 0; busy_err = 0;
        while (!st_done && guard < 300) begin
            if (!st_busy) busy_err = 1;
            @(negedge clk);
            guard++;
        end
        chk(st_done == 1'b1, "R9 done reached", 256'(st_done), 256'(1));
        chk(busy_err == 0 && st_busy == 1'b1, "R9 busy held", 256'(busy_err), 256'(0));
        chk(st_miss == (pre == 3'd0), "R3 miss flag", 256'(st_miss), 256'(pre == 3'd0));
        if (upg) begin
            chk(kills_seen == retries + 1, "R7 kill issues", 256'(kills_seen), 256'(retries + 1));
            chk(ack_seen == 1, "R8 done after ack", 256'(ack_seen), 256'(1));
            chk(inv_bad == 0, "R4 R6 line invalid/addr during kill", 256'(inv_bad), 256'(0));
        end else begin
            chk(kills_seen == 0, "R2 no kill", 256'(kills_seen), 256'(0));
        end
        @(negedge clk);
        chk(mdl_d[idx] == want, "R5 line data", mdl_d[idx], want);
        chk(mdl_s[idx] == ((pre == 3'd0) ? 3'd0 : 3'd4), "R2 R8 line state",
            256'(mdl_s[idx]), 256'((pre == 3'd0) ? 3'd0 : 3'd4));
        exp_d[idx] = want;
        if (pre != 3'd0) exp_s[idx] = 3'd4;
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < NL; i++) begin
            exp_d[i] = {$urandom, $urandom, $urandom, $urandom,
                        $urandom, $urandom, $urandom, $urandom};
            exp_s[i] = 3'($urandom % 5);
            mdl_d[i] = exp_d[i];
            mdl_s[i] = exp_s[i];
        end
        exp_s[0] = 3'd1; exp_s[1] = 3'd2; exp_s[2] = 3'd3; exp_s[3] = 3'd4;
        exp_s[4] = 3'd0; exp_s[5] = 3'd1; exp_s[6] = 3'd2;
        for (int i = 0; i < 7; i++) mdl_s[i] = exp_s[i];
        repeat (3) @(negedge clk);
        chk(!st_busy && !st_done && !kill_req && !c_wr_en && !c_inv_en, "R1 in reset",
            256'({st_busy, st_done, kill_req}), 256'(0));
        rst = 1'b0;
        @(negedge clk);
        chk(!st_busy && !st_done && !st_miss && !kill_req && !c_rd_en, "R1 after reset",
            256'({st_busy, st_done, st_miss, kill_req}), 256'(0));
        // directed corner cases
        do_store({7'd0, 5'h08}, 8'hFF, 64'h1122334455667788, 3);   // R4 R7 shared, retries
        do_store({7'd1, 5'h18}, 8'h81, 64'hA5A5A5A5A5A5A5A5, 0);   // R4 recent, first-try ack
        do_store({7'd2, 5'h00}, 8'h0F, 64'hDEADBEEFCAFEF00D, 0);   // R2 exclusive
        do_store({7'd3, 5'h10}, 8'h00, 64'hFFFFFFFFFFFFFFFF, 0);   // R5 no enables
        do_store({7'd4, 5'h00}, 8'hFF, 64'h0123456789ABCDEF, 0);   // R3 invalid line
        do_store({7'd5, 5'h00}, 8'h3C, 64'h0F0F0F0F0F0F0F0F, 5);   // R7 long retry chain
        do_store({7'd5, 5'h18}, 8'hC3, 64'hF0F0F0F0F0F0F0F0, 0);   // R9 same line again
        do_store({7'd6, 5'h10}, 8'hFF, 64'h5555AAAA5555AAAA, 1);
        // constrained random
        for (int n = 0; n < 120; n++) begin
            logic [11:0] a;
            a = {3'b000, 4'($urandom % 16), 5'($urandom)};
            do_store(a, 8'($urandom), {$urandom, $urandom}, int'($urandom % 4));
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule